// File: doc/BRIEF.md
# Integer-N Synthesizer Digital Core

This block holds the digital part of an integer-N frequency synthesizer. It runs on a fast system clock and samples two slower square waves: the reference clock and the oscillator signal after external division. The reference takes a programmable divider with a ratio of 64 or 128. The oscillator signal first passes a halving stage and then a 16-bit programmable down counter. Each divider gives a one-cycle strobe at its terminal count. A phase-frequency detector compares the two strobe trains and produces up and down requests for an external charge pump. When locked, the oscillator runs at 2 × (reference / ratio) × N.

Besides the detector pulses, the block passes a 2-bit current-level code through to the pump driver. It also drives a tuning-amplifier enable that a disable input forces low, and a lock flag. A 3-bit test code can silence the pump, leave only one pump direction active, or route the divided reference or the halving-stage output to a probe pin. All inputs and outputs are plain level signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. Settings are read live and take effect at the next reload of the counter they feed.

Top module: `synth_core`

## Requirements
- R1: With N in `n_val` (valid range 1024 to 65535), the divided-oscillator strobe occurs once every 2×N rising edges of `osc_in`. With `osc_in` toggling every clock cycle, successive rising edges of a held `pump_up` are 4×N cycles apart.
- R2: `ref_sel` = 1 divides the reference rising edges by 64. `ref_sel` = 0 divides them by 128.
- R3: A change of `n_val` or `ref_sel` leaves the count already in progress untouched. It applies from the next terminal count on.
- R4: An oscillator strobe sets the up request and a reference strobe sets the down request. When both have been seen, both clear, so `pump_up` and `pump_dn` are never high together. Strobes that arrive in the same cycle produce no pulse.
- R5: `pump_cur` always equals `cur_code` (00 lowest current through 11 highest).
- R6: `amp_off` = 1 holds `tune_en` at 0. `amp_off` = 0 gives `tune_en` = 1.
- R7: A `test_code` of 010 or 011 holds both `pump_up` and `pump_dn` at 0.
- R8: `test_code` 110 passes only `pump_dn` and 111 passes only `pump_up`. Codes 000, 001, 100 and 101 pass both.
- R9: `test_code` 100 drives `probe_out` with a level that toggles at each reference terminal count. Code 101 drives it with the halving-stage output, which toggles at each rising edge of `osc_in`. Every other code holds `probe_out` at 0.
- R10: `locked` rises at a reference terminal count once 8 consecutive reference periods have passed in which every up or down pulse lasted fewer than 4 clock cycles. It falls in the cycle in which a pulse reaches 4 cycles.
- R11: After reset, `pump_up`, `pump_dn`, `locked` and `probe_out` are 0, and both dividers give their first strobe on the first qualifying input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference square wave, slower than half the clock rate |
| osc_in | input | 1 | Externally divided oscillator square wave |
| n_val | input | 16 | Programmable counter setting N |
| ref_sel | input | 1 | Reference ratio: 1 gives 64, 0 gives 128 |
| cur_code | input | 2 | Charge-pump current level |
| amp_off | input | 1 | 1 disables the tuning amplifier |
| test_code | input | 3 | Test mode selection |
| pump_up | output | 1 | Source (up) request to the charge pump |
| pump_dn | output | 1 | Sink (down) request to the charge pump |
| pump_cur | output | 2 | Current level passed to the pump driver |
| tune_en | output | 1 | Tuning amplifier enable |
| locked | output | 1 | Lock indication |
| probe_out | output | 1 | Test probe output |

## Verification
If the oscillator counter slips by one count, the spacing between up pulses changes by twice the oscillator period, and this shows within one divided period. If the reference divider keeps a stale reload, the probe interval stays at the old length one period longer than R3 allows. If the detector fails to clear, a pump request stays high right after the opposing strobe. If the lock counter is off by one, `locked` rises a whole reference period early or late. Phase offsets of three and four cycles fall on either side of the lock window.

// File: rtl/synth_pkg.sv
package synth_pkg;

  typedef enum logic [1:0] {
    PRB_NONE = 2'd0,
    PRB_REF  = 2'd1,
    PRB_HALF = 2'd2
  } probe_sel_e;

  typedef struct packed {
    logic       up_ok;
    logic       dn_ok;
    probe_sel_e probe;
  } tmode_t;

  // Test code decode: upper two bits pick the group, bit 0 the variant.
  function automatic tmode_t decode_tmode(input logic [2:0] code);
    tmode_t m;
    m.up_ok = 1'b1;
    m.dn_ok = 1'b1;
    m.probe = PRB_NONE;
    unique case (code[2:1])
      2'b00: ;
      2'b01: begin
        m.up_ok = 1'b0;
        m.dn_ok = 1'b0;
      end
      2'b10: m.probe = code[0] ? PRB_HALF : PRB_REF;
      2'b11: begin
        m.up_ok = code[0];
        m.dn_ok = ~code[0];
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/synth_prescale.sv
module synth_prescale #(
  parameter bit HALVE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic evt,
  output logic tap
);
  logic sig_q;
  logic rise;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;

  generate
    if (HALVE) begin : g_half
      logic phase_q;
      always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= 1'b0;
        else if (rise) phase_q <= ~phase_q;
      end
      // Event on every second input rise: the rise that sets the phase.
      assign evt = rise & ~phase_q;
      assign tap = phase_q;
    end else begin : g_pass
      assign evt = rise;
      assign tap = sig_q;
    end
  endgenerate
endmodule

// File: rtl/synth_div.sv
module synth_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic [W-1:0] reload,
  output logic         tc_pls
);
  logic [W-1:0] cnt_q;

  // Count events down; at zero emit a strobe and take the live reload.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tc_pls <= 1'b0;
    end else begin
      tc_pls <= 1'b0;
      if (evt) begin
        if (cnt_q == '0) begin
          tc_pls <= 1'b1;
          cnt_q  <= reload;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_pls,
  input  logic ref_pls,
  output logic up_q,
  output logic dn_q
);
  logic up_nx;
  logic dn_nx;

  always_comb begin
    up_nx = up_q | osc_pls;
    dn_nx = dn_q | ref_pls;
    if (up_nx && dn_nx) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_nx;
      dn_q <= dn_nx;
    end
  end
endmodule

// File: rtl/synth_lock_mon.sv
module synth_lock_mon #(
  parameter int unsigned WIN  = 4,
  parameter int unsigned NEED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_raw,
  input  logic dn_raw,
  input  logic ref_pls,
  output logic locked
);
  localparam int unsigned WCW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int unsigned GW  = $clog2(NEED + 1);
  localparam logic [WCW-1:0] W_LAST = WCW'(WIN - 1);
  localparam logic [GW-1:0]  G_LAST = GW'(NEED - 1);
  localparam logic [GW-1:0]  G_FULL = GW'(NEED);

  logic [WCW-1:0] wcnt_q;
  logic [GW-1:0]  good_q;
  logic           spoil_q;
  logic           active;
  logic           over;

  assign active = up_raw | dn_raw;
  assign over   = active && (wcnt_q >= W_LAST);

  // Width of the pulse in progress, saturating at the window edge.
  always_ff @(posedge clk) begin
    if (!rst_n)       wcnt_q <= '0;
    else if (!active) wcnt_q <= '0;
    else if (!over)   wcnt_q <= wcnt_q + WCW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_q  <= '0;
      spoil_q <= 1'b0;
      locked  <= 1'b0;
    end else if (ref_pls) begin
      spoil_q <= over;
      if (spoil_q || over) begin
        good_q <= '0;
        locked <= 1'b0;
      end else begin
        if (good_q != G_FULL) good_q <= good_q + GW'(1);
        if (good_q == G_LAST) locked <= 1'b1;
      end
    end else if (over) begin
      spoil_q <= 1'b1;
      good_q  <= '0;
      locked  <= 1'b0;
    end
  end
endmodule

// File: rtl/synth_core.sv
module synth_core #(
  parameter int unsigned N_W       = 16,
  parameter int unsigned REF_LOG2  = 6,
  parameter int unsigned LOCK_WIN  = 4,
  parameter int unsigned LOCK_NEED = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_in,
  input  logic           osc_in,
  input  logic [N_W-1:0] n_val,
  input  logic           ref_sel,
  input  logic [1:0]     cur_code,
  input  logic           amp_off,
  input  logic [2:0]     test_code,
  output logic           pump_up,
  output logic           pump_dn,
  output logic [1:0]     pump_cur,
  output logic           tune_en,
  output logic           locked,
  output logic           probe_out
);
  import synth_pkg::*;

  localparam int unsigned REF_FAST = 1 << REF_LOG2;
  localparam int unsigned REF_SLOW = REF_FAST * 2;
  localparam int unsigned REF_W    = $clog2(REF_SLOW);
  localparam logic [REF_W-1:0] RL_FAST = REF_W'(REF_FAST - 1);
  localparam logic [REF_W-1:0] RL_SLOW = REF_W'(REF_SLOW - 1);

  logic             ref_q;
  logic             ref_evt;
  logic             ref_pls;
  logic             ref_tgl;
  logic [REF_W-1:0] ref_reload;
  logic             osc_evt;
  logic             half_tap;
  logic             osc_pls;
  logic             up_q;
  logic             dn_q;
  tmode_t           tmode;

  // Reference path: edge detect, then 64/128 divider.
  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_in;
  end
  assign ref_evt    = ref_in & ~ref_q;
  assign ref_reload = ref_sel ? RL_FAST : RL_SLOW;

  synth_div #(.W(REF_W)) ref_div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (ref_evt),
    .reload (ref_reload),
    .tc_pls (ref_pls)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ref_tgl <= 1'b0;
    else if (ref_pls) ref_tgl <= ~ref_tgl;
  end

  // Oscillator path: halving stage, then N counter.
  synth_prescale #(.HALVE(1'b1)) osc_pre_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (osc_in),
    .evt    (osc_evt),
    .tap    (half_tap)
  );

  synth_div #(.W(N_W)) osc_div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (osc_evt),
    .reload (n_val - N_W'(1)),
    .tc_pls (osc_pls)
  );

  synth_pfd pfd_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_pls (osc_pls),
    .ref_pls (ref_pls),
    .up_q    (up_q),
    .dn_q    (dn_q)
  );

  synth_lock_mon #(.WIN(LOCK_WIN), .NEED(LOCK_NEED)) lock_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_raw  (up_q),
    .dn_raw  (dn_q),
    .ref_pls (ref_pls),
    .locked  (locked)
  );

  always_comb begin
    tmode   = decode_tmode(test_code);
    pump_up = up_q & tmode.up_ok;
    pump_dn = dn_q & tmode.dn_ok;
    unique case (tmode.probe)
      PRB_REF:  probe_out = ref_tgl;
      PRB_HALF: probe_out = half_tap;
      default:  probe_out = 1'b0;
    endcase
  end

  assign pump_cur = cur_code;
  assign tune_en  = ~amp_off;
endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] test_code,
  input logic       amp_off,
  input logic       tune_en,
  input logic       pump_up,
  input logic       pump_dn,
  input logic       probe_out,
  input logic       locked,
  input logic       ref_pls
);
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  a_r7_pump_off: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code[2:1] == 2'b01) |-> (!pump_up && !pump_dn));

  a_r8_sink_only: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == 3'b110) |-> !pump_up);

  a_r8_source_only: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == 3'b111) |-> !pump_dn);

  a_r6_amp_gate: assert property (@(posedge clk) disable iff (!rst_n)
    amp_off |-> !tune_en);

  a_r9_probe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !test_code[2] |-> !probe_out);

  a_r10_lock_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_pls));
endmodule

bind synth_core synth_core_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_code (test_code),
  .amp_off   (amp_off),
  .tune_en   (tune_en),
  .pump_up   (pump_up),
  .pump_dn   (pump_dn),
  .probe_out (probe_out),
  .locked    (locked),
  .ref_pls   (ref_pls)
);

// File: tb/synth_core_tb.sv
module synth_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic        osc_in = 1'b0;
  logic [15:0] n_val = 16'd1024;
  logic        ref_sel = 1'b1;
  logic [1:0]  cur_code = 2'b00;
  logic        amp_off = 1'b0;
  logic [2:0]  test_code = 3'b000;
  logic        pump_up, pump_dn, tune_en, locked, probe_out;
  logic [1:0]  pump_cur;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // Generator state
  bit ref_run = 0, osc_run = 0;
  int ref_half = 1, osc_half = 1, rc = 0, oc = 0, od = 0;

  // R1: table of N and expected up-pulse spacing (4*N with osc period 2).
  localparam int VEC_N [4] = '{1024, 1025, 1031, 1500};
  localparam int VEC_P [4] = '{4096, 4100, 4124, 6000};
  // {code[2:0], up passes, dn passes, probe with one ref strobe and osc idle}
  localparam logic [5:0] GATE_TAB [8] = '{
    6'b000_11_0, 6'b001_11_0, 6'b010_00_0, 6'b011_00_0,
    6'b100_11_1, 6'b101_11_0, 6'b110_01_0, 6'b111_10_0};
  // {osc delay, expected lock}
  localparam int LK_D [3] = '{4, 3, 0};
  localparam int LK_E [3] = '{0, 1, 1};

  always #5 clk = ~clk;

  synth_core dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .osc_in(osc_in),
    .n_val(n_val), .ref_sel(ref_sel), .cur_code(cur_code),
    .amp_off(amp_off), .test_code(test_code), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_cur(pump_cur), .tune_en(tune_en),
    .locked(locked), .probe_out(probe_out));

  initial forever @(posedge clk) cyc++;

  initial forever @(negedge clk) begin
    if (ref_run) begin
      if (rc == 0) begin ref_in = ~ref_in; rc = ref_half - 1; end
      else rc--;
    end
    if (osc_run) begin
      if (od > 0) od--;
      else if (oc == 0) begin osc_in = ~osc_in; oc = osc_half - 1; end
      else oc--;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic do_reset();
    ref_run = 0; osc_run = 0;
    ref_in = 1'b0; osc_in = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_gen(input bit r, input bit o, input int rh, input int oh, input int d);
    @(posedge clk);
    ref_half = rh; osc_half = oh; rc = 0; oc = 0; od = d;
    ref_run = r; osc_run = o;
  endtask

  task automatic wait_up_rise(input int lim, output int t);
    logic prev;
    t = -1;
    prev = pump_up;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (pump_up && !prev) begin t = cyc; break; end
      prev = pump_up;
    end
  endtask

  task automatic wait_probe_edge(input int lim, output int t);
    logic prev;
    t = -1;
    prev = probe_out;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (probe_out != prev) begin t = cyc; break; end
    end
  endtask

  task automatic ref_burst(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); ref_in = 1'b1;
      @(negedge clk); ref_in = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int t1, t2, t3, t4, hits;

    // R11: reset state
    do_reset();
    check_eq("R11 pump_up after reset", pump_up, 0);
    check_eq("R11 pump_dn after reset", pump_dn, 0);
    check_eq("R11 locked after reset", locked, 0);
    check_eq("R11 probe_out after reset", probe_out, 0);

    // R5 current code passthrough, R6 amplifier enable
    for (int c = 0; c < 4; c++) begin
      cur_code = 2'(c); @(negedge clk);
      check_eq("R5 pump_cur", pump_cur, c);
    end
    amp_off = 1'b1; @(negedge clk);
    check_eq("R6 tune_en disabled", tune_en, 0);
    amp_off = 1'b0; @(negedge clk);
    check_eq("R6 tune_en normal", tune_en, 1);

    // R1: table walk of N settings, R4 clearing after opposing strobe
    for (int i = 0; i < 4; i++) begin
      n_val = 16'(VEC_N[i]); ref_sel = 1'b1; test_code = 3'b000;
      do_reset();
      start_gen(0, 1, 1, 1, 0);
      wait_up_rise(20000, t1);
      repeat (10) @(negedge clk);
      ref_burst(1);
      repeat (3) @(negedge clk);
      check_eq("R4 up cleared by ref strobe", pump_up, 0);
      check_eq("R4 dn not left set", pump_dn, 0);
      wait_up_rise(20000, t2);
      check_eq("R1 up pulse spacing", t2 - t1, VEC_P[i]);
    end

    // R3: new N applies after the count in progress
    n_val = 16'd1024;
    do_reset();
    start_gen(0, 1, 1, 1, 0);
    wait_up_rise(20000, t1);
    n_val = 16'd1030;
    ref_burst(1);
    wait_up_rise(20000, t2);
    check_eq("R3 old N period kept", t2 - t1, 4096);
    repeat (10) @(negedge clk);
    ref_burst(64);
    wait_up_rise(20000, t3);
    check_eq("R3 new N period", t3 - t2, 4120);

    // R7 R8 R9: gating table with up request held
    n_val = 16'd1024;
    do_reset();
    start_gen(0, 1, 1, 1, 0);
    wait_up_rise(20000, t1);
    osc_run = 0;
    for (int i = 0; i < 8; i++) begin
      test_code = GATE_TAB[i][5:3]; @(negedge clk);
      check_eq("R7 R8 up gating", pump_up, GATE_TAB[i][2]);
      check_eq("R4 dn idle with up held", pump_dn, 0);
    end
    // same table with down request held, probe after one ref strobe
    test_code = 3'b000;
    do_reset();
    ref_burst(1);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      test_code = GATE_TAB[i][5:3]; @(negedge clk);
      check_eq("R7 R8 dn gating", pump_dn, GATE_TAB[i][1]);
      check_eq("R4 up idle with dn held", pump_up, 0);
      check_eq("R9 probe level", probe_out, GATE_TAB[i][0]);
    end

    // R2 R3 R9: reference divider through the probe
    test_code = 3'b100; ref_sel = 1'b1;
    do_reset();
    start_gen(1, 0, 1, 1, 0);
    wait_probe_edge(2000, t1);
    wait_probe_edge(2000, t2);
    check_eq("R2 ratio 64 interval", t2 - t1, 128);
    ref_sel = 1'b0;
    wait_probe_edge(2000, t3);
    check_eq("R3 ratio change waits", t3 - t2, 128);
    wait_probe_edge(2000, t4);
    check_eq("R2 ratio 128 interval", t4 - t3, 256);
    ref_sel = 1'b1;

    // R9: halving stage on the probe
    test_code = 3'b101;
    do_reset();
    start_gen(0, 1, 1, 3, 0);
    wait_probe_edge(200, t1);
    wait_probe_edge(200, t2);
    check_eq("R9 half tap interval", t2 - t1, 6);
    wait_probe_edge(200, t3);
    check_eq("R9 half tap next interval", t3 - t2, 6);

    // R10: lock window table
    test_code = 3'b000; n_val = 16'd1024; ref_sel = 1'b1;
    for (int i = 0; i < 3; i++) begin
      do_reset();
      start_gen(1, 1, 32, 1, LK_D[i]);
      hits = 0;
      repeat (30000) begin
        @(negedge clk);
        if (pump_up || pump_dn) hits++;
      end
      check_eq("R10 lock vs phase offset", locked, LK_E[i]);
      if (LK_D[i] == 0) check_eq("R4 coincident strobes give no pulse", hits, 0);
    end
    // R10: drift out of the window drops lock
    n_val = 16'd1025;
    repeat (10000) @(negedge clk);
    check_eq("R10 lock lost on drift", locked, 0);

    finish_run();
  end
endmodule